// File: doc/BRIEF.md
# Escaped Byte Restorer with Abort Detection

This block sits on the receive path of an infrared serial link that protects its flag bytes with a control-escape scheme. Raw received bytes arrive through a valid/ready input. Every escape byte is removed from the stream, and the byte right after it is restored by inverting one bit. Each data byte that results is presented in the same cycle to two destinations: a CRC-checker feed and the write port of a receive FIFO.

The block also watches the raw byte stream, before any restoration, for the two-byte abort pattern. An abort pattern is the only end-of-frame indication an aborted frame carries, so the block answers it with a single-cycle abort pulse. The last byte of the pattern is not forwarded, and the escape state returns to idle. A frame-start input from the flag detector clears any escape state left over from the previous frame. When the FIFO reports full, input ready drops, so the upstream source holds its byte and nothing is lost.

Top module: `sir_unescaper`

## Requirements
- R1: Synchronous active-high reset puts the block in idle: no escape pending, no raw escape remembered, and the abort output low. A byte 0x41 accepted right after reset is forwarded as 0x41.
- R2: `in_ready` equals the inverse of `fifo_full`. While `fifo_full` is high, no byte is accepted and `fifo_wr` and `crc_valid` stay low.
- R3: An accepted byte that is not an escape (0x7D), with no escape pending and no abort, goes out unchanged on `fifo_wdata` and `crc_data` in the same cycle, with `fifo_wr` and `crc_valid` both high.
- R4: An accepted raw 0x7D with no escape pending is dropped (`fifo_wr` and `crc_valid` stay low) and makes the next accepted byte an escaped one.
- R5: The accepted byte after an escape is forwarded with bit 5 inverted (mask 0x20). This includes a second 0x7D, which comes out as 0x5D. After it, the escape state is cleared.
- R6: When an accepted 0xC1 directly follows an accepted raw 0x7D, that 0xC1 is not forwarded, the escape state is cleared, and `frame_abort` is high in the next cycle. This holds whether the 0x7D was an escape or was itself escaped data.
- R7: `frame_start` clears the escape state. A byte accepted in the same cycle is treated as the first byte of a new frame.
- R8: Cycles with no accepted byte (valid low or FIFO full) leave the escape state unchanged.
- R9: `frame_abort` is high for exactly one cycle for each detected abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Start flag seen; clears escape state |
| in_valid | input | 1 | Raw byte available |
| in_data | input | 8 | Raw received byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| fifo_wr | output | 1 | Write strobe for the receive FIFO |
| fifo_wdata | output | 8 | Restored byte for the FIFO |
| crc_valid | output | 1 | Restored byte valid for the CRC checker |
| crc_data | output | 8 | Restored byte for the CRC checker |
| frame_abort | output | 1 | One-cycle pulse after an abort pattern |

## Verification
The assertions assume that `fifo_full` honestly describes the FIFO in the same cycle, and that the source holds `in_data` steady while it waits on a low `in_ready`. The bench drives every input once per cycle, well away from the rising edge, so these assumptions hold. It raises `fifo_full` in the middle of escape and abort sequences to show that the escape state stays put during a stall. The random phase draws bytes mostly from 0x7D, 0xC1, 0x5D and 0xE1 so that escape, double-escape and abort patterns occur often.

// File: rtl/sir_unesc_pkg.sv
package sir_unesc_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned ESC_DEFAULT  = 8'h7D;
    localparam int unsigned ABRT_DEFAULT = 8'hC1;
    localparam int unsigned FLIP_DEFAULT = 5;

    // Escape tracking state carried between accepted bytes
    typedef struct packed {
        logic pend;     // next accepted byte is escaped data
        logic raw_esc;  // last accepted raw byte equalled the escape code
    } esc_state_t;

    // What happens to the byte presented this cycle
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_DROP  = 2'd1,
        ACT_FWD   = 2'd2,
        ACT_ABORT = 2'd3
    } byte_act_e;

    function automatic esc_state_t idle_state();
        esc_state_t s;
        s.pend    = 1'b0;
        s.raw_esc = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/sir_byte_classify.sv
module sir_byte_classify
    import sir_unesc_pkg::*;
#(
    parameter int unsigned W         = BYTE_W,
    parameter logic [W-1:0] ESC_CODE = W'(ESC_DEFAULT),
    parameter logic [W-1:0] ABT_CODE = W'(ABRT_DEFAULT),
    parameter int unsigned FLIP_BIT  = FLIP_DEFAULT
) (
    input  logic        accept,
    input  logic        clear_state,
    input  logic [W-1:0] raw,
    input  esc_state_t  cur,
    output byte_act_e   act,
    output logic [W-1:0] restored,
    output esc_state_t  nxt
);
    localparam logic [W-1:0] FLIP_MASK = W'(1) << FLIP_BIT;

    esc_state_t eff;

    always_comb begin
        eff = clear_state ? idle_state() : cur;
        act = ACT_IDLE;
        restored = raw;
        nxt = eff;
        if (accept) begin
            if (eff.raw_esc && (raw == ABT_CODE)) begin
                act = ACT_ABORT;
                nxt = idle_state();
            end else if (!eff.pend && (raw == ESC_CODE)) begin
                act = ACT_DROP;
                nxt.pend    = 1'b1;
                nxt.raw_esc = 1'b1;
            end else begin
                act = ACT_FWD;
                restored = eff.pend ? (raw ^ FLIP_MASK) : raw;
                nxt.pend    = 1'b0;
                nxt.raw_esc = (raw == ESC_CODE);
            end
        end
    end

endmodule

// File: rtl/sir_esc_state.sv
module sir_esc_state
    import sir_unesc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  esc_state_t nxt,
    output esc_state_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= idle_state();
        else     cur <= nxt;
    end
endmodule

// File: rtl/sir_abort_flag.sv
module sir_abort_flag
    import sir_unesc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_act_e act,
    output logic      abort_q
);
    always_ff @(posedge clk) begin
        if (rst) abort_q <= 1'b0;
        else     abort_q <= (act == ACT_ABORT);
    end

    assert_abort_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> !abort_q);
endmodule

// File: rtl/sir_unescaper.sv
module sir_unescaper
    import sir_unesc_pkg::*;
#(
    parameter int unsigned W         = BYTE_W,
    parameter logic [W-1:0] ESC_CODE = W'(ESC_DEFAULT),
    parameter logic [W-1:0] ABT_CODE = W'(ABRT_DEFAULT),
    parameter int unsigned FLIP_BIT  = FLIP_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         fifo_full,
    output logic         fifo_wr,
    output logic [W-1:0] fifo_wdata,
    output logic         crc_valid,
    output logic [W-1:0] crc_data,
    output logic         frame_abort
);
    localparam logic [W-1:0] FLIP_MASK = W'(1) << FLIP_BIT;

    esc_state_t   st_q, st_d;
    byte_act_e    act;
    logic [W-1:0] restored;
    logic         accept;

    assign in_ready = !fifo_full;
    assign accept   = in_valid && in_ready;

    sir_byte_classify #(
        .W(W), .ESC_CODE(ESC_CODE), .ABT_CODE(ABT_CODE), .FLIP_BIT(FLIP_BIT)
    ) u_classify (
        .accept     (accept),
        .clear_state(frame_start),
        .raw        (in_data),
        .cur        (st_q),
        .act        (act),
        .restored   (restored),
        .nxt        (st_d)
    );

    sir_esc_state u_state (
        .clk(clk), .rst(rst), .nxt(st_d), .cur(st_q)
    );

    sir_abort_flag u_abort (
        .clk(clk), .rst(rst), .act(act), .abort_q(frame_abort)
    );

    assign fifo_wr    = (act == ACT_FWD);
    assign crc_valid  = (act == ACT_FWD);
    assign fifo_wdata = restored;
    assign crc_data   = restored;

    // R2: never write into a full FIFO
    assert_no_write_full_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (!fifo_wr && !crc_valid));

    // R4: an unescaped escape byte never leaves the block
    assert_esc_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !frame_start && !st_q.pend && in_data == ESC_CODE) |-> !fifo_wr);

    // R5: escaped data comes out with the flip bit inverted
    assert_restore_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !frame_start && st_q.pend) |-> (fifo_wdata == (in_data ^ FLIP_MASK)));

    // R6: an abort pulse only follows an accepted abort code after a raw escape
    assert_abort_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_abort) |-> $past(accept && in_data == ABT_CODE));

    // R8: stalled cycles hold the escape state
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!accept && !frame_start) |=> $stable(st_q));

endmodule

// File: tb/tb_sir_unescaper.sv
`timescale 1ns/1ps
module tb_sir_unescaper;
    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start, in_valid, fifo_full;
    logic [7:0] in_data;
    logic       in_ready, fifo_wr, crc_valid, frame_abort;
    logic [7:0] fifo_wdata, crc_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_pend = 0, m_raw = 0, m_abort_next = 0;

    always #2.5 clk = ~clk;

    sir_unescaper dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .crc_valid(crc_valid),
        .crc_data(crc_data), .frame_abort(frame_abort)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one cycle: drive after edge, compare and advance model before next edge
    task automatic step(input bit v, input logic [7:0] d, input bit fs, input bit full, input string req);
        int p, lr, acc, fwd, ab, od;
        @(posedge clk); #1;
        in_valid = v; in_data = d; frame_start = fs; fifo_full = full;
        #2;
        p  = fs ? 0 : m_pend;
        lr = fs ? 0 : m_raw;
        acc = v && !full;
        fwd = 0; ab = 0; od = d;
        if (acc) begin
            if (lr && d == 8'hC1) begin
                ab = 1; p = 0; lr = 0;
            end else if (!p && d == 8'h7D) begin
                p = 1; lr = 1;
            end else begin
                fwd = 1;
                od = p ? (d ^ 8'h20) : d;
                p = 0; lr = (d == 8'h7D);
            end
        end
        chk(req, "in_ready", in_ready, !full);
        chk(req, "fifo_wr", fifo_wr, fwd);
        chk(req, "crc_valid", crc_valid, fwd);
        chk(req, "frame_abort", frame_abort, m_abort_next);
        if (fwd) begin
            chk(req, "fifo_wdata", fifo_wdata, od);
            chk(req, "crc_data", crc_data, od);
        end
        m_pend = p; m_raw = lr; m_abort_next = ab;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; frame_start = 0; in_valid = 0; in_data = 0; fifo_full = 0;
        repeat (3) @(posedge clk);
        #3;
        chk("R1", "frame_abort", frame_abort, 0);
        chk("R1", "fifo_wr", fifo_wr, 0);
        @(posedge clk); #1; rst = 0;

        // R3: plain bytes
        step(1, 8'h41, 0, 0, "R3");
        step(1, 8'hC1, 0, 0, "R3");
        step(0, 8'h00, 0, 0, "R8");
        // R4/R5: escape then restored byte
        step(1, 8'h7D, 0, 0, "R4");
        step(1, 8'h5E, 0, 0, "R5");
        // R5: double escape gives 0x5D
        step(1, 8'h7D, 0, 0, "R4");
        step(1, 8'h7D, 0, 0, "R5");
        // R6: escaped 0x7D followed by raw 0xC1 still aborts
        step(1, 8'hC1, 0, 0, "R6");
        step(0, 8'h00, 0, 0, "R9");
        step(0, 8'h00, 0, 0, "R9");
        // R6: plain abort pattern, then next byte plain
        step(1, 8'h7D, 0, 0, "R4");
        step(1, 8'hC1, 0, 0, "R6");
        step(1, 8'h22, 0, 0, "R6");
        // R2/R8: stall in the middle of an escape
        step(1, 8'h7D, 0, 0, "R4");
        step(1, 8'h33, 0, 1, "R2");
        step(0, 8'h00, 0, 1, "R8");
        step(1, 8'h33, 0, 0, "R8");
        // R7: frame start clears a stray escape
        step(1, 8'h7D, 0, 0, "R4");
        step(1, 8'h44, 1, 0, "R7");
        step(1, 8'h7D, 0, 0, "R4");
        step(0, 8'h00, 1, 0, "R7");
        step(1, 8'hC1, 0, 0, "R7");
        // R1: reset clears pending escape
        step(1, 8'h7D, 0, 0, "R4");
        @(posedge clk); #1; rst = 1; in_valid = 0;
        @(posedge clk); #1; rst = 0;
        m_pend = 0; m_raw = 0; m_abort_next = 0;
        step(1, 8'h41, 0, 0, "R1");

        // random phase biased toward special bytes
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] b;
            int sel;
            sel = $urandom_range(0, 7);
            case (sel)
                0, 1: b = 8'h7D;
                2, 3: b = 8'hC1;
                4:    b = 8'h5D;
                5:    b = 8'hE1;
                default: b = 8'($urandom);
            endcase
            step($urandom_range(0, 4) != 0, b, $urandom_range(0, 15) == 0,
                 $urandom_range(0, 5) == 0, "R5");
        end
        finish_run();
    end
endmodule